// File: doc/BRIEF.md
# Text Buffer Writer and Clearer

This block fills a 4 KB monochrome text video buffer by issuing single-byte memory writes to a bus-write master. Every screen cell takes two bytes. The character code sits at an even offset and its display attribute at the odd offset just above it. The block accepts two commands.

A clear command writes zero into every byte of the visible buffer area. It works downward from offset 0xF9F and ends after offset 0 has been written. A print command takes a starting offset and then consumes a byte stream over a valid/ready handshake. For each non-zero byte it writes the character, followed by the normal-video attribute 0x07 at the next address. A zero byte ends the stream and is never written.

Only one write is outstanding at a time. A one-cycle request goes out, and the block waits for the master's one-cycle acknowledgment before it moves on. A one-cycle done pulse marks the end of each command.

Top module: `vbuf_filler`

## Requirements
- R1: After reset, `wr_req`, `done` and `s_ready` are all low, and nothing is written until a command arrives.
- R2: For each non-zero stream byte, the character is written first at an even offset `a`, then the attribute at offset `a+1`.
- R3: Every attribute byte written by a print command has the value 0x07.
- R4: A zero stream byte ends the print command and is not written. A stream made only of a zero byte completes with no writes.
- R5: Print starts at `cmd_offset` with bit 0 forced to 0, and the cell offset grows by 2 per character.
- R6: Offsets wrap modulo 4096, so a print passing 0xFFF continues at 0x000.
- R7: A clear command writes 0x00 to every offset from 0xF9F down to 0x000 inclusive, in descending order: 4000 writes.
- R8: `wr_req` is a one-cycle pulse. After it, no further request is issued until `wr_done` has been seen.
- R9: `cmd_valid` is ignored while a command is in progress, whether the block is waiting on the stream or on a write.
- R10: `done` is high for exactly one cycle when a command finishes. For clear, this follows the acknowledgment of the write at offset 0; for print, it follows acceptance of the zero byte.
- R11: `s_ready` is high only while the block is waiting for a stream byte, and never in the same cycle as `wr_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_print | input | 1 | 1 = print, 0 = clear |
| cmd_offset | input | 12 | Print start offset (bit 0 ignored) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte, 0x00 terminates |
| s_ready | output | 1 | Block accepts a stream byte |
| wr_req | output | 1 | One-cycle write request to the bus master |
| wr_addr | output | 12 | Buffer offset of the write |
| wr_data | output | 8 | Byte to write |
| wr_done | input | 1 | One-cycle acknowledgment from the bus master |
| done | output | 1 | One-cycle command-finished pulse |

## Verification
The in-RTL assertions check, on every cycle, the following:
- requests are single-cycle and never outstanding twice;
- `s_ready` never coincides with a request;
- print attributes are always 0x07 and clear data always 0x00;
- the offset steps by 2 after each cell;
- a mode cannot change mid-command;
- `done` stays one cycle wide.

The scoreboard bench is needed to show the rest: the exact address order, the terminator behaviour, the empty stream, wrap-around past 0xFFF, the full 4000-byte descending clear, and that a command issued while busy produces no writes at all.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHAR,
    ST_ATTR,
    ST_CLEAR
  } vb_state_t;

  typedef enum logic [1:0] {
    AOP_HOLD,
    AOP_LOAD,
    AOP_ADD2,
    AOP_DEC
  } vb_aop_t;
endpackage

// File: rtl/vbuf_addr.sv
module vbuf_addr
  import vbuf_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  vb_aop_t       op,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP = AW'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else begin
      unique case (op)
        AOP_LOAD: addr <= load_val;
        AOP_ADD2: addr <= addr + STEP;
        AOP_DEC:  addr <= addr - AW'(1);
        default:  addr <= addr;
      endcase
    end
  end

  assert_cell_step_R5: assert property (@(posedge clk) disable iff (rst)
    (op == AOP_ADD2) |=> (addr == $past(addr) + STEP));
  assert_clear_step_R7: assert property (@(posedge clk) disable iff (rst)
    (op == AOP_DEC) |=> (addr == $past(addr) - AW'(1)));
endmodule

// File: rtl/vbuf_seq.sv
module vbuf_seq
  import vbuf_pkg::*;
#(
  parameter int            AW      = 12,
  parameter int            DW      = 8,
  parameter logic [DW-1:0] ATTR    = 8'h07,
  parameter logic [AW-1:0] CLR_TOP = 12'hF9F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_print,
  input  logic [AW-1:0] cmd_offset,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          wr_done,
  input  logic [AW-1:0] cur_addr,
  output vb_aop_t       aop,
  output logic [AW-1:0] load_val,
  output logic          s_ready,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          mode_print
);
  vb_state_t state;
  logic      busy;

  assign busy = (state != ST_IDLE);

  always_comb begin
    aop      = AOP_HOLD;
    load_val = CLR_TOP;
    unique case (state)
      ST_IDLE:
        if (cmd_valid) begin
          aop      = AOP_LOAD;
          load_val = cmd_print ? {cmd_offset[AW-1:1], 1'b0} : CLR_TOP;
        end
      ST_ATTR:  if (wr_done) aop = AOP_ADD2;
      ST_CLEAR: if (wr_done && cur_addr != '0) aop = AOP_DEC;
      default:  aop = AOP_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      s_ready    <= 1'b0;
      wr_req     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
      mode_print <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        ST_IDLE:
          if (cmd_valid) begin
            mode_print <= cmd_print;
            if (cmd_print) begin
              s_ready <= 1'b1;
              state   <= ST_FETCH;
            end else begin
              wr_req  <= 1'b1;
              wr_addr <= CLR_TOP;
              wr_data <= '0;
              state   <= ST_CLEAR;
            end
          end
        ST_FETCH:
          if (s_valid) begin
            s_ready <= 1'b0;
            if (s_data == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              wr_req  <= 1'b1;
              wr_addr <= cur_addr;
              wr_data <= s_data;
              state   <= ST_CHAR;
            end
          end
        ST_CHAR:
          if (wr_done) begin
            wr_req  <= 1'b1;
            wr_addr <= {cur_addr[AW-1:1], 1'b1};
            wr_data <= ATTR;
            state   <= ST_ATTR;
          end
        ST_ATTR:
          if (wr_done) begin
            s_ready <= 1'b1;
            state   <= ST_FETCH;
          end
        ST_CLEAR:
          if (wr_done) begin
            if (cur_addr == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              wr_req  <= 1'b1;
              wr_addr <= cur_addr - AW'(1);
              wr_data <= '0;
            end
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CHAR || state == ST_ATTR || state == ST_CLEAR) && !wr_req && !wr_done) |=> !wr_req);
  assert_ready_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(s_ready && wr_req));
  assert_cmd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> $stable(mode_print));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/vbuf_filler.sv
module vbuf_filler
  import vbuf_pkg::*;
#(
  parameter int            AW      = 12,
  parameter int            DW      = 8,
  parameter logic [DW-1:0] ATTR    = 8'h07,
  parameter logic [AW-1:0] CLR_TOP = 12'hF9F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_print,
  input  logic [AW-1:0] cmd_offset,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_done,
  output logic          done
);
  vb_aop_t       aop;
  logic [AW-1:0] load_val;
  logic [AW-1:0] cur_addr;
  logic          mode_print;

  vbuf_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .op       (aop),
    .load_val (load_val),
    .addr     (cur_addr)
  );

  vbuf_seq #(.AW(AW), .DW(DW), .ATTR(ATTR), .CLR_TOP(CLR_TOP)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_print  (cmd_print),
    .cmd_offset (cmd_offset),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .wr_done    (wr_done),
    .cur_addr   (cur_addr),
    .aop        (aop),
    .load_val   (load_val),
    .s_ready    (s_ready),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done       (done),
    .mode_print (mode_print)
  );

  assert_attr_value_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && mode_print && wr_addr[0]) |-> (wr_data == ATTR));
  assert_char_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && mode_print && !wr_addr[0]) |-> (wr_data != '0));
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !mode_print) |-> (wr_data == '0));
endmodule

// File: tb/vbuf_filler_bench.sv
module vbuf_filler_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_print = 1'b0;
  logic [11:0] cmd_offset = '0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        wr_req;
  logic [11:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_done = 1'b0;
  logic        done;

  int errors = 0;
  int checks = 0;
  int lat = 1;
  int cnt = 0;
  int writes = 0;
  int done_seen = 0;
  logic prev_done = 1'b0;
  logic [19:0] expq[$];

  always #10 clk = ~clk;

  vbuf_filler u_vbuf_filler (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_print(cmd_print),
    .cmd_offset(cmd_offset), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus master model and scoreboard monitor
  always @(negedge clk) begin
    wr_done = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) wr_done = 1'b1;
    end
    if (!rst && wr_req) begin
      logic [19:0] e;
      writes++;
      check(cnt == 0, "R8 request while outstanding", cnt, 0);
      check(!s_ready, "R11 ready with request", s_ready, 0);
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        e = expq.pop_front();
        check({wr_addr, wr_data} == e, "R2 write addr/data", {wr_addr, wr_data}, e);
      end
      cnt = lat;
    end
    if (!rst && done) begin
      done_seen++;
      check(!prev_done, "R10 done width", 2, 1);
    end
    prev_done = done;
  end

  task automatic issue(input bit pr, input logic [11:0] off);
    cmd_valid = 1'b1; cmd_print = pr; cmd_offset = off;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic [11:0] a);
    if (b != 0) begin
      expq.push_back({a, b});
      expq.push_back({a | 12'h001, 8'h07});
    end
    s_valid = 1'b1; s_data = b;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    int start_done = done_seen;
    while (done_seen == start_done && n < 50000) begin
      @(negedge clk);
      n++;
    end
    check(done_seen == start_done + 1, req, done_seen - start_done, 1);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic print_str(input logic [11:0] off, input string s, input string req);
    logic [11:0] a = {off[11:1], 1'b0};
    issue(1'b1, off);
    for (int i = 0; i < s.len(); i++) begin
      send(s[i], a);
      a = a + 12'd2;
    end
    send(8'h00, a);
    wait_done(req);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!wr_req && !done && !s_ready, "R1 reset outputs", {wr_req, done, s_ready}, 0);
    repeat (5) @(negedge clk);
    check(writes == 0, "R1 no writes idle", writes, 0);

    // R2 R3 R5: basic print
    lat = 1;
    print_str(12'h010, "Hi!", "R2 R3 print basic");
    // R5: odd start rounded down, slower bus
    lat = 3;
    print_str(12'h021, "xy", "R5 odd start");
    // R4: empty stream
    w0 = writes;
    print_str(12'h300, "", "R4 empty stream");
    check(writes == w0, "R4 zero not written", writes - w0, 0);
    // R6: wrap past end
    lat = 2;
    print_str(12'hFFE, "AB", "R6 wrap");

    // R9: commands ignored while busy
    issue(1'b1, 12'h100);
    repeat (2) @(negedge clk);
    w0 = writes;
    issue(1'b0, 12'h000);
    repeat (6) @(negedge clk);
    check(writes == w0, "R9 clear ignored while waiting", writes - w0, 0);
    expq.push_back({12'h100, 8'h5A});
    expq.push_back({12'h101, 8'h07});
    s_valid = 1'b1; s_data = 8'h5A;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    issue(1'b1, 12'h800);  // during the write, must be ignored
    send(8'h00, 12'h102);
    wait_done("R9 print completes unchanged");
    repeat (5) @(negedge clk);
    check(writes == w0 + 2, "R9 no extra writes", writes - w0, 2);

    // R7: full clear
    lat = 1;
    w0 = writes;
    for (int a = 12'hF9F; a >= 0; a--) expq.push_back({a[11:0], 8'h00});
    issue(1'b0, 12'h555);
    wait_done("R7 R10 clear");
    check(writes - w0 == 4000, "R7 clear count", writes - w0, 4000);
    @(negedge clk);
    check(!done && !wr_req, "R10 idle after clear", {done, wr_req}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule